// File: doc/BRIEF.md
# Cross-State Call and Return Gate

This block sequences branches from the secure state into the non-secure state and the later return. When the core asks for a state-changing branch whose target has bit 0 clear, the gate saves a two-word frame to secure stack memory. The first word is the return address. The second word packs the current exception number and the secure floating-point-active flag. It then drives a reserved return code on its link output and switches to the non-secure state.

Later, the core may load that reserved code into its program counter. The gate then reads the frame back, hands the return address and the status bits to the core, and resumes in the secure state. The gate also checks entries from the non-secure side: the first fetched word has to be the gateway marker. If it is not, a security fault is raised.

The core holds further requests while `busy` is high. The stack memory is reached through a 32-bit request/acknowledge handshake. The secure stack pointer is kept inside the gate. It moves down by 8 bytes on each save and up by 8 bytes on each restore.

Top module: `xstate_gate`

## Requirements
- R1: After reset the block is in the secure state (`secure`=1), with `busy`=0, `sec_fault`=0, `resume_valid`=0 and `link_out`=0.
- R2: A call request whose target bit 0 (`call_tgt_bit0`) is set, or any call request made in the non-secure state, starts no stack access and changes neither `secure` nor `link_out`.
- R3: A call request in the secure state with target bit 0 clear writes the return address to stack pointer minus 4, and then writes the status word to stack pointer minus 8. The status word holds the exception number in bits [EXC_W-1:0] and the floating-point-active flag in bit EXC_W, with zeros above.
- R4: When the save finishes, `link_out` equals RET_CODE (default 0xFEFFFFFF), `secure` is 0 and `busy` falls.
- R5: The stack pointer starts at SP_RESET (default 0x20000040). It drops by 8 on each save and rises by 8 on each restore, so the next frame lands at the addresses that follow from those steps.
- R6: While `stk_ack` is low, `stk_req` stays high and `stk_addr`, `stk_we` and `stk_wdata` hold steady. No beat completes without an acknowledge.
- R7: A program counter load of any value other than RET_CODE has no effect on `secure`, `busy` or the stack.
- R8: A load of RET_CODE while a frame is saved reads the status word from the stack pointer, then reads the return address from stack pointer plus 4. It then pulses `resume_valid` for one cycle with `resume_pc`, `resume_exc` and `resume_fp` taken from the frame, and sets `secure` to 1.
- R9: A load of RET_CODE while no frame is saved pulses `sec_fault` for one cycle, leaves `secure` unchanged and makes no stack access.
- R10: An entry request in the non-secure state whose fetched word equals MARKER (default 0xE97FE97F) sets `secure` to 1 without a fault.
- R11: An entry request in the non-secure state with any other fetched word pulses `sec_fault`, and the block stays non-secure.
- R12: Nested frames are restored in last-in, first-out order.
- R13: A call made while MAX_FRAMES frames are saved pulses `sec_fault`, makes no stack access and leaves `secure` and `link_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| call_req | input | 1 | State-changing branch request |
| call_tgt_bit0 | input | 1 | Bit 0 of the branch target |
| call_ret_addr | input | 32 | Return address to save |
| call_exc | input | EXC_W | Current exception number |
| call_fp | input | 1 | Secure floating-point-active flag |
| pc_load | input | 1 | Program counter write strobe |
| pc_value | input | 32 | Value written to the program counter |
| entry_req | input | 1 | Non-secure to secure entry attempt |
| fetch_word | input | 32 | First instruction fetched at the entry |
| stk_req | output | 1 | Stack memory request |
| stk_we | output | 1 | Stack write enable |
| stk_addr | output | 32 | Stack byte address |
| stk_wdata | output | 32 | Stack write data |
| stk_ack | input | 1 | Stack acknowledge |
| stk_rdata | input | 32 | Stack read data, valid with acknowledge |
| busy | output | 1 | Sequence in progress; core must wait |
| secure | output | 1 | Current security state |
| link_out | output | 32 | Link value for the core |
| resume_valid | output | 1 | One-cycle pulse: restored context is valid |
| resume_pc | output | 32 | Restored return address |
| resume_exc | output | EXC_W | Restored exception number |
| resume_fp | output | 1 | Restored floating-point-active flag |
| sec_fault | output | 1 | One-cycle security fault pulse |

## Verification
The hardest case to reach is a call that arrives with the frame store already full. The only way to fill it is to alternate calls with valid gateway entries MAX_FRAMES times, because each call leaves the secure state. The bench builds that chain and then issues one more call. It then unwinds all four frames to confirm that the refused call wrote nothing and that frames come back in reverse order. A stalled acknowledge is produced by a bench-held stall flag on the memory model during a save.

// File: rtl/xg_pkg.sv
package xg_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_BEAT0 = 2'd1,
      SQ_BEAT1 = 2'd2
   } seq_state_t;
endpackage

// File: rtl/xg_stack_seq.sv
module xg_stack_seq #(
   parameter int          SW       = 10,
   parameter logic [31:0] SP_RESET = 32'h2000_0040
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_push,
   input  logic          start_pop,
   input  logic [31:0]   push_ret,
   input  logic [SW-1:0] push_status,
   output logic          active,
   output logic          dir_push,
   output logic          last_ack,
   output logic [31:0]   pop_ret,
   output logic [SW-1:0] pop_status,
   output logic          stk_req,
   output logic          stk_we,
   output logic [31:0]   stk_addr,
   output logic [31:0]   stk_wdata,
   input  logic          stk_ack,
   input  logic [31:0]   stk_rdata
);
   import xg_pkg::*;

   localparam logic [31:0] FRAME_BYTES = 32'd8;

   seq_state_t    st_q;
   logic          push_q;
   logic [31:0]   sp_q;
   logic [31:0]   ret_q;
   logic [SW-1:0] status_q;

   assign active   = (st_q != SQ_IDLE);
   assign dir_push = push_q;
   assign stk_req  = active;
   assign stk_we   = active & push_q;
   assign last_ack = (st_q == SQ_BEAT1) & stk_ack;
   assign pop_ret  = stk_rdata;
   assign pop_status = status_q;

   always_comb begin
      stk_addr  = sp_q;
      stk_wdata = '0;
      if (push_q) begin
         if (st_q == SQ_BEAT0) begin
            stk_addr  = sp_q - 32'd4;
            stk_wdata = ret_q;
         end else begin
            stk_addr  = sp_q - FRAME_BYTES;
            stk_wdata = {{(32-SW){1'b0}}, status_q};
         end
      end else if (st_q == SQ_BEAT1) begin
         stk_addr = sp_q + 32'd4;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         push_q   <= 1'b0;
         sp_q     <= SP_RESET;
         ret_q    <= '0;
         status_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (start_push) begin
                  st_q     <= SQ_BEAT0;
                  push_q   <= 1'b1;
                  ret_q    <= push_ret;
                  status_q <= push_status;
               end else if (start_pop) begin
                  st_q   <= SQ_BEAT0;
                  push_q <= 1'b0;
               end
            end
            SQ_BEAT0: begin
               if (stk_ack) begin
                  st_q <= SQ_BEAT1;
                  if (!push_q) status_q <= stk_rdata[SW-1:0];
               end
            end
            SQ_BEAT1: begin
               if (stk_ack) begin
                  st_q   <= SQ_IDLE;
                  push_q <= 1'b0;
                  sp_q   <= push_q ? (sp_q - FRAME_BYTES) : (sp_q + FRAME_BYTES);
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // R6: a beat without acknowledge keeps its request stable
   a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_req && !stk_ack) |=> (stk_req && $stable(stk_addr) && $stable(stk_wdata) && $stable(stk_we)));

   // R5: stack pointer moves by one frame per finished sequence
   a_r5_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (last_ack && push_q) |=> (sp_q == $past(sp_q) - FRAME_BYTES));
endmodule

// File: rtl/xg_code_match.sv
module xg_code_match #(
   parameter logic [31:0] RET_CODE   = 32'hFEFF_FFFF,
   parameter logic [31:0] MARKER     = 32'hE97F_E97F,
   parameter bit          GATE_CHECK = 1'b1
) (
   input  logic [31:0] pc_value,
   input  logic [31:0] fetch_word,
   output logic        is_ret,
   output logic        gate_ok
);
   assign is_ret = (pc_value == RET_CODE);

   generate
      if (GATE_CHECK) begin : g_check
         assign gate_ok = (fetch_word == MARKER);
      end else begin : g_open
         logic unused_fetch;
         assign unused_fetch = ^fetch_word;
         assign gate_ok = 1'b1 | unused_fetch;
      end
   endgenerate
endmodule

// File: rtl/xstate_gate.sv
module xstate_gate #(
   parameter int          EXC_W      = 9,
   parameter int          MAX_FRAMES = 4,
   parameter logic [31:0] RET_CODE   = 32'hFEFF_FFFF,
   parameter logic [31:0] MARKER     = 32'hE97F_E97F,
   parameter logic [31:0] SP_RESET   = 32'h2000_0040,
   parameter bit          GATE_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             call_req,
   input  logic             call_tgt_bit0,
   input  logic [31:0]      call_ret_addr,
   input  logic [EXC_W-1:0] call_exc,
   input  logic             call_fp,
   input  logic             pc_load,
   input  logic [31:0]      pc_value,
   input  logic             entry_req,
   input  logic [31:0]      fetch_word,
   output logic             stk_req,
   output logic             stk_we,
   output logic [31:0]      stk_addr,
   output logic [31:0]      stk_wdata,
   input  logic             stk_ack,
   input  logic [31:0]      stk_rdata,
   output logic             busy,
   output logic             secure,
   output logic [31:0]      link_out,
   output logic             resume_valid,
   output logic [31:0]      resume_pc,
   output logic [EXC_W-1:0] resume_exc,
   output logic             resume_fp,
   output logic             sec_fault
);
   localparam int SW = EXC_W + 1;
   localparam int DW = $clog2(MAX_FRAMES + 1);
   localparam logic [DW-1:0] DEPTH_FULL = DW'(MAX_FRAMES);

   initial begin
      if (EXC_W < 1 || EXC_W > 30) $error("xstate_gate: EXC_W out of range");
      if (MAX_FRAMES < 1) $error("xstate_gate: MAX_FRAMES must be positive");
      if (SP_RESET[2:0] != 3'b000) $error("xstate_gate: SP_RESET must be 8-byte aligned");
   end

   logic          secure_q, fault_q, rv_q, rfp_q;
   logic [31:0]   link_q, rpc_q;
   logic [EXC_W-1:0] rexc_q;
   logic [DW-1:0] depth_q;

   logic          seq_active, seq_push, seq_last;
   logic [31:0]   pop_ret;
   logic [SW-1:0] pop_status;
   logic          is_ret, gate_ok;

   logic idle, call_ok, do_push, push_full, ret_hit, do_pop, ret_empty;
   logic entry_hit, entry_bad;

   assign idle      = ~seq_active;
   assign call_ok   = idle & call_req & ~call_tgt_bit0 & secure_q;
   assign push_full = call_ok & (depth_q == DEPTH_FULL);
   assign do_push   = call_ok & (depth_q != DEPTH_FULL);
   assign ret_hit   = idle & ~call_req & pc_load & is_ret;
   assign do_pop    = ret_hit & (depth_q != '0);
   assign ret_empty = ret_hit & (depth_q == '0);
   assign entry_hit = idle & ~call_req & ~pc_load & entry_req & ~secure_q;
   assign entry_bad = entry_hit & ~gate_ok;

   xg_code_match #(
      .RET_CODE  (RET_CODE),
      .MARKER    (MARKER),
      .GATE_CHECK(GATE_CHECK)
   ) u_match (
      .pc_value  (pc_value),
      .fetch_word(fetch_word),
      .is_ret    (is_ret),
      .gate_ok   (gate_ok)
   );

   xg_stack_seq #(
      .SW      (SW),
      .SP_RESET(SP_RESET)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_push (do_push),
      .start_pop  (do_pop),
      .push_ret   (call_ret_addr),
      .push_status({call_fp, call_exc}),
      .active     (seq_active),
      .dir_push   (seq_push),
      .last_ack   (seq_last),
      .pop_ret    (pop_ret),
      .pop_status (pop_status),
      .stk_req    (stk_req),
      .stk_we     (stk_we),
      .stk_addr   (stk_addr),
      .stk_wdata  (stk_wdata),
      .stk_ack    (stk_ack),
      .stk_rdata  (stk_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secure_q <= 1'b1;
         link_q   <= '0;
         depth_q  <= '0;
         fault_q  <= 1'b0;
         rv_q     <= 1'b0;
         rpc_q    <= '0;
         rexc_q   <= '0;
         rfp_q    <= 1'b0;
      end else begin
         fault_q <= push_full | ret_empty | entry_bad;
         rv_q    <= 1'b0;
         if (entry_hit && gate_ok) secure_q <= 1'b1;
         if (seq_last) begin
            if (seq_push) begin
               secure_q <= 1'b0;
               link_q   <= RET_CODE;
               depth_q  <= depth_q + 1'b1;
            end else begin
               secure_q <= 1'b1;
               depth_q  <= depth_q - 1'b1;
               rv_q     <= 1'b1;
               rpc_q    <= pop_ret;
               rexc_q   <= pop_status[EXC_W-1:0];
               rfp_q    <= pop_status[EXC_W];
            end
         end
      end
   end

   assign busy         = seq_active;
   assign secure       = secure_q;
   assign link_out     = link_q;
   assign resume_valid = rv_q;
   assign resume_pc    = rpc_q;
   assign resume_exc   = rexc_q;
   assign resume_fp    = rfp_q;
   assign sec_fault    = fault_q;

   // R4: the non-secure state is only reachable with a saved frame
   a_r4_ns_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !secure_q |-> (depth_q != '0));

   // R8: a restore always lands in the secure state
   a_r8_resume_secure: assert property (@(posedge clk) disable iff (!rst_n)
      resume_valid |-> secure);

   // R9: fault is a single-cycle pulse
   a_r9_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sec_fault |=> !sec_fault);

   // R13: a full frame store starts no stack access
   a_r13_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      push_full |=> !stk_req);

   // R2: a call with target bit 0 set starts nothing
   a_r2_bit0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_req && call_tgt_bit0) |=> (!busy && $stable(link_out)));
endmodule

// File: tb/xstate_gate_test.sv
module xstate_gate_test;
   localparam logic [31:0] RET = 32'hFEFF_FFFF;
   localparam logic [31:0] MRK = 32'hE97F_E97F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        call_req = 0, call_tgt_bit0 = 0, call_fp = 0;
   logic [31:0] call_ret_addr = 0;
   logic [8:0]  call_exc = 0;
   logic        pc_load = 0, entry_req = 0;
   logic [31:0] pc_value = 0, fetch_word = 0;
   logic        stk_req, stk_we, stk_ack, busy, secure, resume_valid, resume_fp, sec_fault;
   logic [31:0] stk_addr, stk_wdata, stk_rdata, link_out, resume_pc;
   logic [8:0]  resume_exc;

   logic        mem_stall = 0;
   logic [31:0] mem [16];
   int          wr_count = 0, acc_count = 0;

   assign stk_ack   = stk_req & ~mem_stall;
   assign stk_rdata = mem[stk_addr[5:2]];

   always @(posedge clk) begin
      if (stk_req && stk_ack) begin
         acc_count <= acc_count + 1;
         if (stk_we) begin
            mem[stk_addr[5:2]] <= stk_wdata;
            wr_count <= wr_count + 1;
         end
      end
   end

   xstate_gate uut (
      .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_tgt_bit0(call_tgt_bit0),
      .call_ret_addr(call_ret_addr), .call_exc(call_exc), .call_fp(call_fp),
      .pc_load(pc_load), .pc_value(pc_value), .entry_req(entry_req), .fetch_word(fetch_word),
      .stk_req(stk_req), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
      .stk_ack(stk_ack), .stk_rdata(stk_rdata), .busy(busy), .secure(secure),
      .link_out(link_out), .resume_valid(resume_valid), .resume_pc(resume_pc),
      .resume_exc(resume_exc), .resume_fp(resume_fp), .sec_fault(sec_fault)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_call(input logic [31:0] ra, input logic [8:0] ex, input logic fp, input logic b0);
      @(negedge clk);
      call_req = 1; call_tgt_bit0 = b0; call_ret_addr = ra; call_exc = ex; call_fp = fp;
      @(negedge clk);
      call_req = 0; call_tgt_bit0 = 0;
      wait_idle();
   endtask

   task automatic do_pc(input logic [31:0] v);
      @(negedge clk);
      pc_load = 1; pc_value = v;
      @(negedge clk);
      pc_load = 0;
   endtask

   task automatic do_entry(input logic [31:0] w);
      @(negedge clk);
      entry_req = 1; fetch_word = w;
      @(negedge clk);
      entry_req = 0;
   endtask

   task automatic t_reset();
      chk("R1 secure", secure, 1);
      chk("R1 busy", busy, 0);
      chk("R1 fault", sec_fault, 0);
      chk("R1 resume_valid", resume_valid, 0);
      chk("R1 link", link_out, 0);
   endtask

   task automatic t_bit0_set();
      int w0 = wr_count;
      do_call(32'h0C00_0200, 9'h3, 1'b0, 1'b1);
      chk("R2 no write", wr_count, w0);
      chk("R2 secure kept", secure, 1);
      chk("R2 link kept", link_out, 0);
   endtask

   task automatic t_call_stall();
      int w0 = wr_count;
      logic [31:0] a0;
      @(negedge clk);
      mem_stall = 1;
      call_req = 1; call_ret_addr = 32'h0C00_0120; call_exc = 9'h015; call_fp = 1;
      @(negedge clk);
      call_req = 0;
      a0 = stk_addr;
      @(negedge clk);
      chk("R6 req held", stk_req, 1);
      chk("R6 addr held", stk_addr, a0);
      chk("R6 no write during stall", wr_count, w0);
      mem_stall = 0;
      wait_idle();
      chk("R3 ret word at sp-4", mem[15], 32'h0C00_0120);
      chk("R3 status word at sp-8", mem[14], 32'h0000_0215);
      chk("R4 link code", link_out, RET);
      chk("R4 non-secure", secure, 0);
   endtask

   task automatic t_other_pc();
      int a0 = acc_count;
      do_pc(32'h0800_1000);
      chk("R7 no access", acc_count, a0);
      chk("R7 still non-secure", secure, 0);
      chk("R7 busy low", busy, 0);
   endtask

   task automatic t_gate_bad();
      do_entry(32'h1234_5678);
      chk("R11 fault", sec_fault, 1);
      @(negedge clk);
      chk("R11 stays non-secure", secure, 0);
   endtask

   task automatic t_return_one();
      @(negedge clk);
      pc_load = 1; pc_value = RET;
      @(negedge clk);
      pc_load = 0;
      wait_idle();
      chk("R8 resume_valid", resume_valid, 1);
      chk("R8 resume_pc", resume_pc, 32'h0C00_0120);
      chk("R8 resume_exc", resume_exc, 9'h015);
      chk("R8 resume_fp", resume_fp, 1);
      chk("R8 secure", secure, 1);
      @(negedge clk);
      chk("R8 pulse one cycle", resume_valid, 0);
   endtask

   task automatic t_return_empty();
      int a0 = acc_count;
      do_pc(RET);
      chk("R9 fault", sec_fault, 1);
      chk("R9 secure unchanged", secure, 1);
      chk("R9 no access", acc_count, a0);
   endtask

   task automatic t_nested_full();
      int w0;
      logic [31:0] lk;
      for (int i = 0; i < 4; i++) begin
         do_call(32'h0C00_1000 + 32'(i * 16), 9'(i + 1), i[0], 1'b0);
         do_entry(MRK);
         chk("R10 gateway entry", secure, 1);
         chk("R10 no fault", sec_fault, 0);
      end
      chk("R5 fourth frame ret", mem[9], 32'h0C00_1030);
      chk("R5 fourth frame status", mem[8], 32'h0000_0204);
      w0 = wr_count;
      lk = link_out;
      @(negedge clk);
      call_req = 1; call_ret_addr = 32'hDEAD_0000;
      @(negedge clk);
      call_req = 0;
      chk("R13 fault", sec_fault, 1);
      chk("R13 no push", stk_req, 0);
      chk("R13 no write", wr_count, w0);
      chk("R13 secure kept", secure, 1);
      chk("R13 link kept", link_out, lk);
      for (int i = 3; i >= 0; i--) begin
         @(negedge clk);
         pc_load = 1; pc_value = RET;
         @(negedge clk);
         pc_load = 0;
         wait_idle();
         chk("R12 lifo pc", resume_pc, 32'h0C00_1000 + 32'(i * 16));
         chk("R12 lifo exc", 32'(resume_exc), 32'(i + 1));
      end
      do_call(32'h0C00_0300, 9'h0, 1'b0, 1'b0);
      chk("R5 sp back at reset", mem[15], 32'h0C00_0300);
      do_call(32'h0C00_0400, 9'h0, 1'b0, 1'b0);
      chk("R2 call in non-secure ignored", mem[13] !== 32'h0C00_0400, 1);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_bit0_set();
      t_call_stall();
      t_other_pc();
      t_gate_bad();
      t_return_one();
      t_return_empty();
      t_nested_full();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule